// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit RISC processor core, together with the eight-bit status register that it updates. Each cycle it takes two byte operands, a five-bit operation code and a three-bit bit selector. It produces a byte result, a write enable for that result, and the next value of the status flags.

The result and the next flag value are combinational. The status register loads the next flag value on a rising clock edge when an operation-valid strobe is high. Every operation rewrites only its own group of flags and keeps the others. This lets the surrounding core chain carry through multi-byte arithmetic, and it lets a flag that was set on purpose survive a logic operation.

Instruction fetch, decode, the register file, word-wide immediate arithmetic, memory access and branching belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: The status register holds, from bit 7 down to bit 0: interrupt-enable I, transfer bit T, half carry H, sign S, overflow V, negative N, zero Z and carry C. It resets to 0x00, and `result_we` is low while no operation is valid.
- R2: `sreg_q` loads `sreg_next` on a rising clock edge only while `op_valid` is high. Otherwise it holds its value. Flags that the current operation does not name never change.
- R3: Codes 0 (add) and 1 (add with carry) output `opa + opb (+C)` and write it. C is the carry out of bit 7 and H is the carry out of bit 3. V is set on signed overflow, N is result bit 7, and Z is set for a zero result. I and T keep their values.
- R4: Codes 2 (subtract) and 3 (subtract with carry) output `opa - opb (-C)` and write it. Codes 4 (compare) and 5 (compare with carry) compute the same value but do not write it. All four set C to the borrow out of bit 7 and H to the borrow out of bit 3, and they also update V, N and Z. I and T keep their values.
- R5: Codes 6 (AND), 7 (OR) and 8 (XOR) write the bitwise result. They clear V, update N and Z, and keep C, H, I and T.
- R6: Code 11 (increment, `opa+1`) sets V when the result is 0x80. Code 12 (decrement, `opa-1`) sets V when the result is 0x7F. Both update only Z, N, V and S.
- R7: Code 9 (one's complement) writes 0xFF minus `opa`, sets C, clears V, and updates Z and N. Code 10 (two's complement) writes 0x00 minus `opa`. It sets C when the result is not zero, sets V when the result is 0x80, sets H to the borrow out of bit 3, and updates Z and N.
- R8: Code 13 shifts left and code 14 shifts right, both inserting 0. Code 15 rotates left with the old C entering bit 0. Code 16 rotates right with the old C entering bit 7. The bit shifted out goes to C, V becomes N XOR C, and Z and N are updated.
- R9: Code 17 (arithmetic shift right) keeps bit 7, moves bits 7..1 down one place, and puts bit 0 into C. Its flags follow R8.
- R10: Code 18 writes `{opa[3:0], opa[7:4]}` and changes no flag.
- R11: Code 19 copies `opa[bit_sel]` into T without writing a result. Code 20 writes `opa` with bit `bit_sel` replaced by T and changes no flag.
- R12: Code 21 sets, and code 22 clears, status bit `bit_sel` using the layout of R1. Neither changes any other bit or writes a result.
- R13: S equals N XOR V after every operation that updates N or V.
- R14: `result_we` is high only while `op_valid` is high and the code is one of 0-3 or 6-18 or 20. Codes 23-31 output `opa`, write nothing and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation valid; enables the status load and the result write |
| op_sel | input | 5 | Operation code |
| opa | input | 8 | First operand; the single operand of unary operations |
| opb | input | 8 | Second operand |
| bit_sel | input | 3 | Operand bit or status bit selector |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result write enable |
| sreg_q | output | 8 | Current status register |
| sreg_next | output | 8 | Status value that loads on a valid operation |

## Verification
The bench targets the boundaries where flag logic usually breaks:
- Signed overflow at 0x7F+1 and 0x80-1.
- The nibble carry at 0x0F+1 and the nibble borrow in 0x00-1.
- The two's complement of 0x00 and of 0x80.
- Rotates that carry a set C into the opposite end.
- An arithmetic shift of a negative byte.

A design that took the borrow polarity the wrong way would invert C on every subtract. A design that recomputed S from stale N or V would leave S disagreeing with them. A logic operation that overwrote C or H would erase a flag set just before it. A compare that raised the write enable would corrupt the register file.

Thousands of random operations with random valid gaps check that unnamed flags and idle cycles leave the register untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int OPW   = 5;
    localparam int NFLAG = 8;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18,
        OP_BST  = 5'd19,
        OP_BLD  = 5'd20,
        OP_FSET = 5'd21,
        OP_FCLR = 5'd22
    } alu_op_e;

    // status bit positions (the core's flag decode depends on them)
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;

    // update groups
    localparam logic [NFLAG-1:0] M_ARITH = 8'b0011_1111; // H S V N Z C
    localparam logic [NFLAG-1:0] M_ZNVC  = 8'b0001_1111; // S V N Z C
    localparam logic [NFLAG-1:0] M_ZNV   = 8'b0001_1110; // S V N Z

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic         sub,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int HB = W/2 - 1;

    logic [W-1:0]  y_eff;
    logic          c_eff;
    logic [W:0]    full;
    logic [HB+1:0] low;

    // subtraction as x + ~y + ~cin; borrow is the inverted carry
    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
        low   = {1'b0, x[HB:0]} + {1'b0, y_eff[HB:0]} + {{(HB+1){1'b0}}, c_eff};
        r     = full[W-1:0];
        c_out = sub ? ~full[W] : full[W];
        h_out = sub ? ~low[HB+1] : low[HB+1];
        v_out = (x[W-1] == y_eff[W-1]) && (full[W-1] != x[W-1]);
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         c_out
);
    always_comb begin
        r     = a;
        c_out = cin;
        case (op)
            OP_LSL: begin r = {a[W-2:0], 1'b0};    c_out = a[W-1]; end
            OP_LSR: begin r = {1'b0, a[W-1:1]};    c_out = a[0];   end
            OP_ROL: begin r = {a[W-2:0], cin};     c_out = a[W-1]; end
            OP_ROR: begin r = {cin, a[W-1:1]};     c_out = a[0];   end
            OP_ASR: begin r = {a[W-1], a[W-1:1]};  c_out = a[0];   end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W    = 8,
    parameter int SELW = 3
) (
    input  alu_op_e         op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SELW-1:0] sel,
    input  logic            t_in,
    output logic [W-1:0]    r,
    output logic            v_out
);
    localparam int             HALF     = W/2;
    localparam logic [W-1:0]   SIGN_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0]   POS_MAX  = ~SIGN_MIN;
    localparam logic [W-1:0]   ONE      = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        r     = a;
        v_out = 1'b0;
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_INC:  begin r = a + ONE; v_out = (a == POS_MAX);  end
            OP_DEC:  begin r = a - ONE; v_out = (a == SIGN_MIN); end
            OP_SWAP: r = {a[HALF-1:0], a[W-1:HALF]};
            OP_BLD:  r[sel] = t_in;
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NFLAG-1:0] upd_mask,
    input  logic [NFLAG-1:0] upd_val,
    output logic [NFLAG-1:0] sreg_q,
    output logic [NFLAG-1:0] sreg_next
);
    genvar gi;
    generate
        for (gi = 0; gi < NFLAG; gi++) begin : g_flag
            assign sreg_next[gi] = upd_mask[gi] ? upd_val[gi] : sreg_q[gi];

            AST_KEEP_UNNAMED: assert property (@(posedge clk) disable iff (!rst_n)
                load && !upd_mask[gi] |=> sreg_q[gi] == $past(sreg_q[gi])); // R2
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (load)
            sreg_q <= sreg_next;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sreg_q)); // R2

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = DW,
    localparam int SELW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPW-1:0]   op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [SELW-1:0]  bit_sel,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [NFLAG-1:0] sreg_q,
    output logic [NFLAG-1:0] sreg_next
);
    alu_op_e          op;
    logic             c_now;
    logic             t_now;

    logic             as_sub;
    logic [WIDTH-1:0] as_x;
    logic [WIDTH-1:0] as_y;
    logic             as_cin;
    logic [WIDTH-1:0] as_r;
    logic             as_c;
    logic             as_h;
    logic             as_v;

    logic [WIDTH-1:0] sh_r;
    logic             sh_c;
    logic [WIDTH-1:0] lg_r;
    logic             lg_v;

    logic [WIDTH-1:0] res;
    logic             wr;
    logic [NFLAG-1:0] mask;
    logic [NFLAG-1:0] val;
    logic             fc;
    logic             fh;
    logic             fv;
    logic             tbit;
    logic             flag_op;

    assign op    = alu_op_e'(op_sel);
    assign c_now = sreg_q[F_C];
    assign t_now = sreg_q[F_T];

    // adder/subtractor operand routing
    always_comb begin
        as_sub = 1'b1;
        as_x   = opa;
        as_y   = opb;
        as_cin = 1'b0;
        case (op)
            OP_ADD:         as_sub = 1'b0;
            OP_ADC: begin   as_sub = 1'b0; as_cin = c_now; end
            OP_SBC, OP_CPC: as_cin = c_now;
            OP_NEG: begin   as_x = '0; as_y = opa; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(WIDTH)) u_addsub (
        .sub   (as_sub),
        .x     (as_x),
        .y     (as_y),
        .cin   (as_cin),
        .r     (as_r),
        .c_out (as_c),
        .h_out (as_h),
        .v_out (as_v)
    );

    alu8_shift #(.W(WIDTH)) u_shift (
        .op    (op),
        .a     (opa),
        .cin   (c_now),
        .r     (sh_r),
        .c_out (sh_c)
    );

    alu8_logic #(.W(WIDTH), .SELW(SELW)) u_logic (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .sel   (bit_sel),
        .t_in  (t_now),
        .r     (lg_r),
        .v_out (lg_v)
    );

    // result selection and flag group decode
    always_comb begin
        res     = opa;
        wr      = 1'b0;
        mask    = '0;
        fc      = 1'b0;
        fh      = 1'b0;
        fv      = 1'b0;
        tbit    = t_now;
        flag_op = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                res = as_r; wr = 1'b1; mask = M_ARITH;
                fc = as_c; fh = as_h; fv = as_v;
            end
            OP_CMP, OP_CPC: begin
                res = as_r; mask = M_ARITH;
                fc = as_c; fh = as_h; fv = as_v;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                res = lg_r; wr = 1'b1; mask = M_ZNV; fv = lg_v;
            end
            OP_COM: begin
                res = ~opa; wr = 1'b1; mask = M_ZNVC; fc = 1'b1;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res = sh_r; wr = 1'b1; mask = M_ZNVC;
                fc = sh_c; fv = sh_r[WIDTH-1] ^ sh_c;
            end
            OP_SWAP, OP_BLD: begin
                res = lg_r; wr = 1'b1;
            end
            OP_BST: begin
                mask = NFLAG'(1) << F_T; tbit = opa[bit_sel];
            end
            OP_FSET, OP_FCLR: begin
                mask = NFLAG'(1) << bit_sel; flag_op = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        val      = '0;
        val[F_C] = fc;
        val[F_Z] = (res == '0);
        val[F_N] = res[WIDTH-1];
        val[F_V] = fv;
        val[F_S] = res[WIDTH-1] ^ fv;
        val[F_H] = fh;
        val[F_T] = tbit;
        if (flag_op)
            val = {NFLAG{op == OP_FSET}};
    end

    alu8_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (op_valid),
        .upd_mask  (mask),
        .upd_val   (val),
        .sreg_q    (sreg_q),
        .sreg_next (sreg_next)
    );

    assign result    = res;
    assign result_we = op_valid & wr;

    AST_SIGN_IS_N_XOR_V: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel <= 5'd17) |=> sreg_q[F_S] == (sreg_q[F_N] ^ sreg_q[F_V])); // R13

    AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel <= 5'd17) |=> sreg_q[F_Z] == ($past(result) == '0)); // R3

    AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel >= 5'd6) && (op_sel <= 5'd8)
        |=> sreg_q[F_C] == $past(sreg_q[F_C]) && sreg_q[F_H] == $past(sreg_q[F_H])); // R5

    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel == 5'd18) |=> sreg_q == $past(sreg_q)); // R10

    AST_UNUSED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel > 5'd22) |=> sreg_q == $past(sreg_q)); // R14

    AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 5'd4) || (op_sel == 5'd5) |-> !result_we); // R4

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] sreg_q;
    logic [7:0] sreg_next;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model_sreg = 8'h00;

    always #2 clk = ~clk;

    alu8_core u_alu8_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_sel    (op_sel),
        .opa       (opa),
        .opb       (opb),
        .bit_sel   (bit_sel),
        .result    (result),
        .result_we (result_we),
        .sreg_q    (sreg_q),
        .sreg_next (sreg_next)
    );

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] op);
        if (op <= 5'd1)  return "R3";
        if (op <= 5'd5)  return "R4";
        if (op <= 5'd8)  return "R5";
        if (op <= 5'd10) return "R7";
        if (op <= 5'd12) return "R6";
        if (op <= 5'd16) return "R8";
        if (op == 5'd17) return "R9";
        if (op == 5'd18) return "R10";
        if (op <= 5'd20) return "R11";
        if (op <= 5'd22) return "R12";
        return "R14";
    endfunction

    // independent reference: integer arithmetic on the requirement text
    function automatic void ref_model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                                      input logic [2:0] bs, input logic [7:0] s,
                                      output logic [7:0] r, output logic we, output logic [7:0] ns);
        int ua, ub, sa, sb, ci, tot, st;
        logic fc, fh, fv;
        logic [7:0] upd;
        ua = int'(a); ub = int'(b);
        sa = a[7] ? ua - 256 : ua;
        sb = b[7] ? ub - 256 : ub;
        ci = 0; r = a; we = 1'b0; ns = s; upd = 8'h00;
        fc = 1'b0; fh = 1'b0; fv = 1'b0;
        case (op)
            5'd0, 5'd1: begin
                ci = (op == 5'd1) ? int'(s[0]) : 0;
                tot = ua + ub + ci; st = sa + sb + ci;
                r = 8'(tot); we = 1'b1; upd = 8'h3F;
                fc = tot > 255; fh = ((ua % 16) + (ub % 16) + ci) > 15;
                fv = (st > 127) || (st < -128);
            end
            5'd2, 5'd3, 5'd4, 5'd5: begin
                ci = (op == 5'd3 || op == 5'd5) ? int'(s[0]) : 0;
                tot = ua - ub - ci; st = sa - sb - ci;
                r = 8'(tot); we = (op < 5'd4); upd = 8'h3F;
                fc = tot < 0; fh = (ua % 16) < ((ub % 16) + ci);
                fv = (st > 127) || (st < -128);
            end
            5'd10: begin
                r = 8'(-ua); we = 1'b1; upd = 8'h3F;
                fc = (ua != 0); fh = (ua % 16) != 0; fv = (a == 8'h80);
            end
            5'd6:  begin r = a & b; we = 1'b1; upd = 8'h1E; end
            5'd7:  begin r = a | b; we = 1'b1; upd = 8'h1E; end
            5'd8:  begin r = a ^ b; we = 1'b1; upd = 8'h1E; end
            5'd11: begin r = 8'(ua + 1); we = 1'b1; upd = 8'h1E; fv = (r == 8'h80); end
            5'd12: begin r = 8'(ua - 1); we = 1'b1; upd = 8'h1E; fv = (r == 8'h7F); end
            5'd9:  begin r = 8'(255 - ua); we = 1'b1; upd = 8'h1F; fc = 1'b1; end
            5'd13: begin r = 8'(ua * 2); fc = a[7]; we = 1'b1; upd = 8'h1F; end
            5'd14: begin r = 8'(ua / 2); fc = a[0]; we = 1'b1; upd = 8'h1F; end
            5'd15: begin r = 8'(ua * 2 + int'(s[0])); fc = a[7]; we = 1'b1; upd = 8'h1F; end
            5'd16: begin r = 8'(ua / 2 + 128 * int'(s[0])); fc = a[0]; we = 1'b1; upd = 8'h1F; end
            5'd17: begin r = 8'(ua / 2 + (a[7] ? 128 : 0)); fc = a[0]; we = 1'b1; upd = 8'h1F; end
            5'd18: begin r = 8'((ua % 16) * 16 + ua / 16); we = 1'b1; end
            5'd19: ns[6] = a[bs];
            5'd20: begin r = a; r[bs] = s[6]; we = 1'b1; end
            5'd21: ns[bs] = 1'b1;
            5'd22: ns[bs] = 1'b0;
            default: ;
        endcase
        if (upd[0]) ns[0] = fc;
        if (upd[1]) ns[1] = (r == 8'h00);
        if (upd[2]) ns[2] = r[7];
        if (upd[3]) ns[3] = upd[0] && (op >= 5'd13) && (op <= 5'd17) ? (r[7] ^ fc) : fv;
        if (upd[4]) ns[4] = r[7] ^ ns[3];
        if (upd[5]) ns[5] = fh;
    endfunction

    task automatic run_op(input logic v, input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] bs);
        logic [7:0] er, ens, exp_q;
        logic ewe;
        string tag;
        tag = v ? tag_of(op) : "R2";
        @(negedge clk);
        op_valid = v; op_sel = op; opa = a; opb = b; bit_sel = bs;
        ref_model(op, a, b, bs, model_sreg, er, ewe, ens);
        #1;
        check(tag, "result", result, er);
        check((op == 5'd4 || op == 5'd5) ? "R4" : "R14", "result_we", {7'b0, result_we}, {7'b0, ewe & v});
        if (v) check(tag, "sreg_next", sreg_next, ens);
        exp_q = v ? ens : model_sreg;
        @(posedge clk);
        #1;
        check(tag, "sreg_q", sreg_q, exp_q);
        model_sreg = exp_q;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset sreg_q", sreg_q, 8'h00);
        check("R1", "reset result_we", {7'b0, result_we}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: set then clear every status bit
        for (int i = 0; i < 8; i++) run_op(1'b1, 5'd21, 8'h00, 8'h00, 3'(i));
        check("R12", "all set", sreg_q, 8'hFF);
        for (int i = 0; i < 8; i++) run_op(1'b1, 5'd22, 8'h00, 8'h00, 3'(i));

        // R3 / R13: signed overflow and nibble carry
        run_op(1'b1, 5'd0, 8'h7F, 8'h01, 3'd0);
        check("R13", "S after 7F+1", {7'b0, sreg_q[4]}, {7'b0, sreg_q[2] ^ sreg_q[3]});
        check("R3", "V,N,H after 7F+1", {5'b0, sreg_q[5], sreg_q[3], sreg_q[2]}, 8'h07);
        run_op(1'b1, 5'd21, 8'h00, 8'h00, 3'd0);          // C=1
        run_op(1'b1, 5'd1, 8'hFF, 8'h00, 3'd0);           // R3 adc -> 0, Z C H
        run_op(1'b1, 5'd2, 8'h00, 8'h01, 3'd0);           // R4 borrow
        run_op(1'b1, 5'd4, 8'h55, 8'h55, 3'd0);           // R4 compare equal, no write
        run_op(1'b1, 5'd10, 8'h80, 8'h00, 3'd0);          // R7
        run_op(1'b1, 5'd10, 8'h00, 8'h00, 3'd0);          // R7
        run_op(1'b1, 5'd11, 8'h7F, 8'h00, 3'd0);          // R6
        run_op(1'b1, 5'd12, 8'h80, 8'h00, 3'd0);          // R6
        run_op(1'b1, 5'd21, 8'h00, 8'h00, 3'd5);          // H=1
        run_op(1'b1, 5'd21, 8'h00, 8'h00, 3'd0);          // C=1
        run_op(1'b1, 5'd6, 8'hF0, 8'h0F, 3'd0);           // R5 keeps C,H
        check("R5", "C,H kept", {6'b0, sreg_q[5], sreg_q[0]}, 8'h03);
        run_op(1'b1, 5'd15, 8'h80, 8'h00, 3'd0);          // R8 rol
        run_op(1'b1, 5'd16, 8'h01, 8'h00, 3'd0);          // R8 ror
        run_op(1'b1, 5'd17, 8'h81, 8'h00, 3'd0);          // R9
        run_op(1'b1, 5'd18, 8'h3C, 8'h00, 3'd0);          // R10
        run_op(1'b1, 5'd19, 8'h20, 8'h00, 3'd5);          // R11 T=1
        run_op(1'b1, 5'd20, 8'h00, 8'h00, 3'd2);          // R11 -> 0x04
        run_op(1'b1, 5'd25, 8'hA5, 8'h5A, 3'd1);          // R14
        run_op(1'b0, 5'd0, 8'hFF, 8'hFF, 3'd0);           // R2 idle

        for (int i = 0; i < 4000; i++) begin
            run_op(($urandom % 8) != 0, 5'($urandom), 8'($urandom), 8'($urandom), 3'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule